// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer for 9-bit words whose writer and reader run on unrelated clocks. The depth is a power of two from 256 to 8192 words. It reports its fill level through four active-low flags. Two of them come from the writer's clock: full and almost-full. The other two come from the reader's clock: empty and almost-empty. Each pointer is passed to the other clock domain as a Gray code through a chain of synchronizer flops. A flag therefore moves at once when its own side acts. When the other side acts, the flag follows a few cycles later. A flag never shows a safer level than the real one.

The almost-empty and almost-full thresholds are set by two offset registers. Reset loads both with 7. The second write pin has two possible roles, chosen by its level while reset is held. If it is high during reset, it becomes a second write enable. If it is low during reset, it becomes a load strobe: a write with the strobe raised puts the data word into an offset register instead of the queue. Successive loads fill the empty offset first, then the full offset, and then wrap back to the empty offset. A read needs both read enables. The data output is driven only while the output enable is high.

Top module: `dcfifo_prog`

## Requirements
- R1: `full_n` goes low on the write clock edge that brings the word count to DEPTH. While it is low, write attempts store nothing: later reads return the words held before.
- R2: `empty_n` is low whenever no word is held. A read attempted while it is low leaves `q` and the read pointer unchanged.
- R3: `afull_n` is low exactly when count >= DEPTH - m, where m is the full offset (7 after reset). It is therefore never high while `full_n` is low.
- R4: `aempty_n` is low exactly when count <= n, where n is the empty offset (7 after reset). It is therefore never high while `empty_n` is low.
- R5: `wr_en2_ld` is sampled on each write clock edge while `rst_n` is low, and its role is then fixed until the next reset. If it was sampled at 1, a word is written only when `wr_en` and `wr_en2_ld` are both 1.
- R6: If `wr_en2_ld` was sampled at 0 during reset, a cycle with `wr_en`=1 and `wr_en2_ld`=1 loads `din` into an offset register and does not enqueue. The order is empty offset, then full offset, then the empty offset again. A cycle with `wr_en`=1 and `wr_en2_ld`=0 enqueues.
- R7: During and after reset, with no traffic: `empty_n`=0, `aempty_n`=0, `full_n`=1, `afull_n`=1, both offsets are 7, and `q`=0 while `oe`=1.
- R8: While `oe`=0, `q` is high-impedance and the held word does not appear on it. Raising `oe` shows the held word again.
- R9: A read takes place only when `rd_en_a` and `rd_en_b` are both 1 at the read clock edge. With either one low, the count and `q` are unchanged.
- R10: Words leave in the order they were written. `q` takes the word that was read on the read clock edge of that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset for both sides; the clocks may keep running |
| wr_en | input | 1 | Primary write enable, active high |
| wr_en2_ld | input | 1 | Second write enable or offset load strobe; its role is chosen during reset |
| din | input | 9 | Write data, also the source of offset loads |
| rd_en_a | input | 1 | First read enable, active high |
| rd_en_b | input | 1 | Second read enable, active high |
| oe | input | 1 | Output enable for `q` |
| q | output | 9 | Read data; high-impedance while `oe` is low |
| full_n | output | 1 | Low when DEPTH words are held (write clock) |
| afull_n | output | 1 | Low at DEPTH-m words or more (write clock) |
| aempty_n | output | 1 | Low at n words or fewer (read clock) |
| empty_n | output | 1 | Low when no word is held (read clock) |

## Verification
A blocked access and a flag update can fall on the same edge. This happens when a write is attempted on the edge that makes the FIFO full, or on the next one, and when a read is attempted while the FIFO is empty. The bench provokes these cases by writing one word past a full FIFO, reading one word past an empty one, and offering reads with only one of the two enables. It then judges the result by draining the FIFO and comparing the words, `q` and the settled flags with a queue model that it keeps itself. An offset load and the threshold change it causes also meet on the write side. These are judged by moving the count across the newly loaded empty and full thresholds.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
   // role of the dual-purpose write pin, captured during reset
   typedef enum logic {
      PIN_LOAD   = 1'b0,
      PIN_WREN2  = 1'b1
   } pin_role_e;

   localparam int DEF_OFFSET = 7;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[gi] <= '0;
               else        chain[gi] <= chain[gi-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
   import dcf_pkg::*;
#(
   parameter int DEPTH = 256,
   parameter int DW    = 9,
   parameter int PW    = 9,
   parameter int CW    = 10
) (
   input  logic          wclk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_pin,
   input  logic [DW-1:0] din,
   input  logic [PW-1:0] rgray_s,
   output logic [PW-1:0] wbin,
   output logic [PW-1:0] wgray,
   output logic          wr_do,
   output logic          full_n,
   output logic          afull_n,
   output logic [DW-1:0] ofs_empty,
   output pin_role_e     role
);
   logic [PW-1:0] wbin_nx, rbin_s, wcnt_nx;
   logic [DW-1:0] ofs_full;
   logic          ld_do, ld_sel;

   function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   // role capture: the pin is sampled on every edge while reset is held
   always_ff @(posedge wclk)
      if (!rst_n) role <= pin_role_e'(wr_pin);

   always_comb begin
      wr_do   = wr_en && full_n &&
                ((role == PIN_WREN2) ? wr_pin : !wr_pin);
      ld_do   = wr_en && (role == PIN_LOAD) && wr_pin;
      rbin_s  = gray2bin(rgray_s);
      wbin_nx = wbin + {{(PW-1){1'b0}}, wr_do};
      wcnt_nx = wbin_nx - rbin_s;
   end

   always_ff @(posedge wclk or negedge rst_n)
      if (!rst_n) begin
         wbin    <= '0;
         wgray   <= '0;
         full_n  <= 1'b1;
         afull_n <= 1'b1;
      end else begin
         wbin    <= wbin_nx;
         wgray   <= wbin_nx ^ (wbin_nx >> 1);
         full_n  <= (wcnt_nx != PW'(DEPTH));
         afull_n <= !((CW'(wcnt_nx) + CW'(ofs_full)) >= CW'(DEPTH));
      end

   // offset registers: empty offset first, then full offset, then wrap
   always_ff @(posedge wclk or negedge rst_n)
      if (!rst_n) begin
         ofs_empty <= DW'(DEF_OFFSET);
         ofs_full  <= DW'(DEF_OFFSET);
         ld_sel    <= 1'b0;
      end else if (ld_do) begin
         if (!ld_sel) ofs_empty <= din;
         else         ofs_full  <= din;
         ld_sel <= ~ld_sel;
      end
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
   parameter int DW = 9,
   parameter int PW = 9,
   parameter int CW = 10
) (
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          rd_en_a,
   input  logic          rd_en_b,
   input  logic [PW-1:0] wgray_s,
   input  logic [DW-1:0] ofs_empty,
   output logic [PW-1:0] rbin,
   output logic [PW-1:0] rgray,
   output logic          rd_do,
   output logic          empty_n,
   output logic          aempty_n
);
   logic [PW-1:0] rbin_nx, wbin_s, rcnt_nx;

   function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   always_comb begin
      rd_do   = rd_en_a && rd_en_b && empty_n;
      wbin_s  = gray2bin(wgray_s);
      rbin_nx = rbin + {{(PW-1){1'b0}}, rd_do};
      rcnt_nx = wbin_s - rbin_nx;
   end

   always_ff @(posedge rclk or negedge rst_n)
      if (!rst_n) begin
         rbin     <= '0;
         rgray    <= '0;
         empty_n  <= 1'b0;
         aempty_n <= 1'b0;
      end else begin
         rbin     <= rbin_nx;
         rgray    <= rbin_nx ^ (rbin_nx >> 1);
         empty_n  <= (rcnt_nx != '0);
         aempty_n <= (CW'(rcnt_nx) > CW'(ofs_empty));
      end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
   parameter int DEPTH = 256,
   parameter int DW    = 9,
   parameter int AW    = 8
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge wclk)
      if (we) mem[waddr] <= wdata;

   always_ff @(posedge rclk or negedge rst_n)
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
endmodule

// File: rtl/dcfifo_prog.sv
module dcfifo_prog
   import dcf_pkg::*;
#(
   parameter int DEPTH       = 256,
   parameter int DW          = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_en2_ld,
   input  logic [DW-1:0] din,
   input  logic          rd_en_a,
   input  logic          rd_en_b,
   input  logic          oe,
   output logic [DW-1:0] q,
   output logic          full_n,
   output logic          afull_n,
   output logic          aempty_n,
   output logic          empty_n
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   localparam int CW = ((PW > DW) ? PW : DW) + 1;

   generate
      if (DEPTH < 256 || DEPTH > 8192 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("dcfifo_prog: DEPTH must be a power of two in 256..8192");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dcfifo_prog: SYNC_STAGES must be at least 2");
      end
      if (DW < 1) begin : g_bad_width
         $error("dcfifo_prog: DW must be positive");
      end
   endgenerate

   logic [PW-1:0] wbin, wgray, rbin, rgray, wgray_s, rgray_s;
   logic [DW-1:0] ofs_empty, q_reg;
   logic          wr_do, rd_do;
   pin_role_e     role;

   dcf_wr_ctl #(.DEPTH(DEPTH), .DW(DW), .PW(PW), .CW(CW)) u_wr (
      .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .wr_pin(wr_en2_ld),
      .din(din), .rgray_s(rgray_s), .wbin(wbin), .wgray(wgray),
      .wr_do(wr_do), .full_n(full_n), .afull_n(afull_n),
      .ofs_empty(ofs_empty), .role(role)
   );

   dcf_rd_ctl #(.DW(DW), .PW(PW), .CW(CW)) u_rd (
      .rclk(rclk), .rst_n(rst_n), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
      .wgray_s(wgray_s), .ofs_empty(ofs_empty), .rbin(rbin), .rgray(rgray),
      .rd_do(rd_do), .empty_n(empty_n), .aempty_n(aempty_n)
   );

   dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
   );

   dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
   );

   dcf_ram #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_ram (
      .wclk(wclk), .we(wr_do), .waddr(wbin[AW-1:0]), .wdata(din),
      .rclk(rclk), .rst_n(rst_n), .re(rd_do), .raddr(rbin[AW-1:0]),
      .rdata(q_reg)
   );

   assign q = oe ? q_reg : {DW{1'bz}};
endmodule

// File: rtl/dcfifo_prog_chk.sv
module dcfifo_prog_chk
   import dcf_pkg::*;
#(
   parameter int PW = 9
) (
   input logic          wclk,
   input logic          rclk,
   input logic          rst_n,
   input logic          rd_en_a,
   input logic          rd_en_b,
   input logic          full_n,
   input logic          afull_n,
   input logic          empty_n,
   input logic          aempty_n,
   input logic [PW-1:0] wbin,
   input logic [PW-1:0] rbin,
   input pin_role_e     role
);
   // R1: no pointer advance while full
   p_no_overflow_r1: assert property (@(posedge wclk) disable iff (!rst_n)
      !full_n |=> $stable(wbin));

   // R2: no pointer advance while empty
   p_no_underflow_r2: assert property (@(posedge rclk) disable iff (!rst_n)
      !empty_n |=> $stable(rbin));

   // R3: almost-full accompanies full
   p_afull_with_full_r3: assert property (@(posedge wclk) disable iff (!rst_n)
      !full_n |-> !afull_n);

   // R4: almost-empty accompanies empty
   p_aempty_with_empty_r4: assert property (@(posedge rclk) disable iff (!rst_n)
      !empty_n |-> !aempty_n);

   // R5: pin role frozen outside reset
   p_role_held_r5: assert property (@(posedge wclk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(role));

   // R9: read pointer waits for both enables
   p_read_gate_r9: assert property (@(posedge rclk) disable iff (!rst_n)
      !(rd_en_a && rd_en_b) |=> $stable(rbin));

   // R10: pointers move by at most one per edge
   p_wstep_r10: assert property (@(posedge wclk) disable iff (!rst_n)
      $past(rst_n) |-> (wbin == $past(wbin) || wbin == $past(wbin) + 1'b1));
endmodule

bind dcfifo_prog dcfifo_prog_chk #(.PW(PW)) u_chk (
   .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .rd_en_a(rd_en_a),
   .rd_en_b(rd_en_b), .full_n(full_n), .afull_n(afull_n),
   .empty_n(empty_n), .aempty_n(aempty_n), .wbin(wbin), .rbin(rbin),
   .role(role)
);

// File: tb/sim_dcfifo_prog.sv
module sim_dcfifo_prog;
   localparam int DEPTH = 256;
   localparam int DW    = 9;
   localparam int NV    = 12;
   // vector table: writes then reads per step; flags judged after settling
   localparam int VW [NV] = '{1, 6, 1, 240, 1, 6, 1, 1, 0, 0, 0, 0};
   localparam int VR [NV] = '{0, 0, 0, 0,   0, 0, 0, 0, 1, 248, 7, 1};

   logic wclk = 1'b0, rclk = 1'b0;
   always #4 wclk = ~wclk;   // 125 MHz
   always #5 rclk = ~rclk;

   logic          rst_n = 1'b0, wr_en = 1'b0, wr_en2_ld = 1'b1;
   logic [DW-1:0] din = '0;
   logic          rd_en_a = 1'b0, rd_en_b = 1'b0, oe = 1'b1;
   wire  [DW-1:0] q;
   logic          full_n, afull_n, aempty_n, empty_n;

   dcfifo_prog #(.DEPTH(DEPTH), .DW(DW)) u0 (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_en2_ld(wr_en2_ld), .din(din), .rd_en_a(rd_en_a),
      .rd_en_b(rd_en_b), .oe(oe), .q(q), .full_n(full_n),
      .afull_n(afull_n), .aempty_n(aempty_n), .empty_n(empty_n)
   );

   int            n_chk = 0, n_fail = 0, seq = 0;
   int            exp_n = 7, exp_m = 7;
   bit            dual = 1'b1, ld_next_full = 1'b0, done = 1'b0;
   logic [DW-1:0] mq [$];
   logic [DW-1:0] last_q = '0;

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset(input logic pinv);
      rst_n = 1'b0; wr_en = 1'b0; rd_en_a = 1'b0; rd_en_b = 1'b0; wr_en2_ld = pinv;
      repeat (4) @(posedge wclk);
      @(negedge wclk);
      rst_n = 1'b1;
      mq.delete(); exp_n = 7; exp_m = 7; dual = pinv; ld_next_full = 1'b0; last_q = '0;
      wr_en2_ld = dual;
   endtask

   task automatic wr_word(input logic [DW-1:0] d, input logic pinv);
      @(negedge wclk);
      wr_en = 1'b1; din = d; wr_en2_ld = pinv;
      @(posedge wclk);
      if (dual ? pinv : !pinv) begin
         if (mq.size() < DEPTH) mq.push_back(d);
      end else if (!dual && pinv) begin
         if (ld_next_full) exp_m = int'(d); else exp_n = int'(d);
         ld_next_full = !ld_next_full;
      end
   endtask

   task automatic rd_try(input logic a, input logic b);
      @(negedge rclk);
      rd_en_a = a; rd_en_b = b;
      @(posedge rclk);
      @(negedge rclk);
      rd_en_a = 1'b0; rd_en_b = 1'b0;
      if (a && b && mq.size() > 0) begin
         last_q = mq.pop_front();
         check("R10", "read data", int'(q), int'(last_q));
      end else begin
         check("R2/R9", "q after blocked read", int'(q), int'(last_q));
      end
   endtask

   task automatic settle();
      @(negedge wclk);
      wr_en = 1'b0; wr_en2_ld = dual;
      repeat (8) @(posedge rclk);
      repeat (8) @(posedge wclk);
      @(negedge wclk);
   endtask

   task automatic check_flags(input string tag);
      int cnt;
      cnt = mq.size();
      check("R1", {tag, " full_n"},   int'(full_n),   int'(cnt != DEPTH));
      check("R3", {tag, " afull_n"},  int'(afull_n),  int'(cnt < DEPTH - exp_m));
      check("R4", {tag, " aempty_n"}, int'(aempty_n), int'(cnt > exp_n));
      check("R2", {tag, " empty_n"},  int'(empty_n),  int'(cnt != 0));
   endtask

   function automatic logic [DW-1:0] pat();
      seq++;
      return DW'((seq * 37 + 5) & 9'h1FF);
   endfunction

   initial begin
      // R7: reset values
      do_reset(1'b1);
      @(negedge wclk);
      check("R7", "empty_n", int'(empty_n), 0);
      check("R7", "aempty_n", int'(aempty_n), 0);
      check("R7", "full_n", int'(full_n), 1);
      check("R7", "afull_n", int'(afull_n), 1);
      check("R7", "q", int'(q), 0);

      // R5: second enable low blocks the write
      wr_word(9'h0F0, 1'b0);
      settle();
      check("R5", "empty_n after single-enable write", int'(empty_n), 0);

      // R9: one read enable alone does nothing
      wr_word(9'h1A5, 1'b1);
      settle();
      rd_try(1'b1, 1'b0);
      rd_try(1'b0, 1'b1);
      settle();
      check("R9", "empty_n after one-enable reads", int'(empty_n), 1);
      rd_try(1'b1, 1'b1);
      settle();

      // R8: output enable
      oe = 1'b0; #1;
      check("R8", "held word hidden", int'(q !== 9'h1A5), 1);
      oe = 1'b1; #1;
      check("R8", "held word shown", int'(q), 9'h1A5);

      // vector table: fill through the thresholds, overflow, drain, underflow
      for (int v = 0; v < NV; v++) begin
         for (int k = 0; k < VW[v]; k++) wr_word(pat(), 1'b1);
         settle();
         for (int k = 0; k < VR[v]; k++) rd_try(1'b1, 1'b1);
         settle();
         check_flags($sformatf("vec%0d", v));
      end

      // R6: load mode, three loads wrap back to the empty offset
      do_reset(1'b0);
      wr_word(9'd3, 1'b1);
      wr_word(9'd10, 1'b1);
      wr_word(9'd5, 1'b1);
      settle();
      check("R6", "loads do not enqueue", int'(empty_n), 0);
      for (int k = 0; k < 5; k++) wr_word(pat(), 1'b0);
      settle();
      check("R6", "aempty_n at n=5 words", int'(aempty_n), 0);
      check_flags("r6_5");
      wr_word(pat(), 1'b0);
      settle();
      check("R6", "aempty_n at 6 words", int'(aempty_n), 1);
      for (int k = 0; k < 239; k++) wr_word(pat(), 1'b0);
      settle();
      check("R6", "afull_n at 245 words (m=10)", int'(afull_n), 1);
      wr_word(pat(), 1'b0);
      settle();
      check("R6", "afull_n at 246 words (m=10)", int'(afull_n), 0);
      check_flags("r6_246");
      for (int k = 0; k < 4; k++) rd_try(1'b1, 1'b1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1_400_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule